// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Engine

This block turns bytes into asynchronous serial frames on a single output line and recovers bytes from an incoming line. The frame shape and the bit rate come from two configuration bytes. A mode byte selects the character length, the stop-bit count, parity and a clock prescaler. A rate byte divides the prescaled clock further. A surrounding register layer supplies bytes for transmission through a valid/taken handshake. It collects each received character together with per-character event pulses.

The engine only raises raw events: a byte taken for transmission, a character received, and the overrun, framing-error and parity-error conditions that go with it. Storing those events as status flags and turning them into interrupts is left to the surrounding logic. A one-cycle read strobe from that logic marks the last received character as consumed. Overrun is judged against that strobe. The transmit and receive halves have separate enables, and each half is held idle while its enable is low.

Top module: `afe_top`

## Requirements
- R1: The transmit line idles high. A frame is one low start bit, then the data bits least-significant bit first, then the parity bit when enabled, then the stop bits at high level.
- R2: Mode bit 5 set gives 7-bit characters and clear gives 8-bit characters. In 7-bit mode, transmit data bit 7 is not sent and received data bit 7 reads 0.
- R3: Mode bit 2 set gives two stop bits and clear gives one. The receiver checks only the first stop bit.
- R4: Mode bit 4 enables parity. Mode bit 3 then selects odd parity (set) or even parity (clear). Bit 3 has no effect on the frame or on error reporting while bit 4 is clear.
- R5: With clock select s = mode bits [1:0] and rate byte N, one bit lasts 32·4^s·(N+1) clock cycles, and the receiver oversamples 16 times per bit.
- R6: `tx_taken_o` pulses for one cycle when a byte presented on `tx_valid_i` is loaded. A held `tx_valid_i` starts the next frame right after the previous one, so consecutive frames are spaced exactly one frame length apart.
- R7: While `tx_en_i` is low, the transmit line stays high and no byte is taken.
- R8: While `rx_en_i` is low, no character is reported.
- R9: Each received character gives a one-cycle `rx_done_o` pulse with the data on `rx_data_o`.
- R10: `rx_frame_err_o` pulses with `rx_done_o` when the first stop bit is sampled low.
- R11: `rx_parity_err_o` pulses with `rx_done_o` when parity is enabled and the received parity bit does not match the selected sense.
- R12: `rx_overrun_o` pulses with `rx_done_o` when the character completes while the previous one has not been read through `rx_read_i`.
- R13: A low pulse that is shorter than half a bit is treated as a glitch: the receiver returns to idle and reports nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 8 | Mode byte: [1:0] clock select, 2 two stop bits, 3 odd parity, 4 parity enable, 5 seven-bit characters |
| rate_i | input | 8 | Bit-rate divisor N |
| tx_en_i | input | 1 | Transmit half enable |
| rx_en_i | input | 1 | Receive half enable |
| tx_valid_i | input | 1 | A byte is ready for transmission |
| tx_data_i | input | 8 | Byte to transmit |
| tx_taken_o | output | 1 | One-cycle pulse: byte loaded into the shifter |
| tx_line_o | output | 1 | Serial output line |
| rx_line_i | input | 1 | Serial input line (asynchronous) |
| rx_read_i | input | 1 | Last received character has been consumed |
| rx_data_o | output | 8 | Received character |
| rx_done_o | output | 1 | One-cycle pulse: character received |
| rx_overrun_o | output | 1 | Overrun, valid with rx_done_o |
| rx_frame_err_o | output | 1 | Framing error, valid with rx_done_o |
| rx_parity_err_o | output | 1 | Parity error, valid with rx_done_o |

## Verification
The properties assume that the mode byte does not change while a character is being received. The 7-bit and parity properties compare the completed character with the mode one cycle earlier. The bench changes mode and rate only when both the line and the transmitter are idle and every expected character has been drained. It holds the serial input high between frames for at least two bit times, so every start edge follows an armed, idle receiver. Injected glitches stay below a quarter of a bit, well inside the half-bit rejection window.

// File: rtl/afe_pkg.sv
package afe_pkg;
   localparam int DATA_W  = 8;
   localparam int FRAME_W = DATA_W + 4;
   localparam int LEN_W   = $clog2(FRAME_W + 1);

   typedef struct packed {
      logic [1:0] spare;
      logic       short_char;
      logic       par_on;
      logic       par_odd;
      logic       two_stop;
      logic [1:0] clk_sel;
   } afe_mode_t;

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
   } rx_state_e;

   function automatic int data_bits(afe_mode_t m);
      return m.short_char ? DATA_W - 1 : DATA_W;
   endfunction

   function automatic logic [LEN_W-1:0] frame_len(afe_mode_t m);
      return LEN_W'(1 + data_bits(m) + (m.par_on ? 1 : 0) + (m.two_stop ? 2 : 1));
   endfunction

   // start bit in position 0, then data LSB first, optional parity, stop ones
   function automatic logic [FRAME_W-1:0] frame_bits(logic [DATA_W-1:0] d, afe_mode_t m);
      logic [FRAME_W-1:0] v;
      int                 pos;
      logic               par;
      v   = '1;
      v[0] = 1'b0;
      pos = 1;
      par = m.par_odd;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < data_bits(m)) begin
            v[pos] = d[i];
            par    = par ^ d[i];
            pos    = pos + 1;
         end
      end
      if (m.par_on) v[pos] = par;
      return v;
   endfunction
endpackage

// File: rtl/afe_baud.sv
module afe_baud #(
   parameter int CKS_W         = 2,
   parameter int RATE_W        = 8,
   parameter int PRE_BASE      = 2,
   parameter int PRE_STEP_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CKS_W-1:0]  clk_sel,
   input  logic [RATE_W-1:0] rate,
   output logic              os_tick
);
   localparam int PRE_W = $clog2(PRE_BASE) + PRE_STEP_LOG2 * ((1 << CKS_W) - 1) + 1;

   if (PRE_BASE < 1) begin : g_bad_base
      $error("afe_baud: PRE_BASE must be at least 1");
   end
   if (PRE_STEP_LOG2 < 1) begin : g_bad_step
      $error("afe_baud: PRE_STEP_LOG2 must be at least 1");
   end

   logic [PRE_W-1:0]  pre_cnt;
   logic [PRE_W-1:0]  pre_lim;
   logic [RATE_W-1:0] div_cnt;
   logic              pre_wrap;
   logic              div_wrap;

   always_comb begin
      pre_lim  = PRE_W'((PRE_BASE << (PRE_STEP_LOG2 * int'(clk_sel))) - 1);
      pre_wrap = (pre_cnt >= pre_lim);
      div_wrap = (div_cnt >= rate);
      os_tick  = run && pre_wrap && div_wrap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else if (!run) begin
         pre_cnt <= '0;
         div_cnt <= '0;
      end else begin
         pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
         if (pre_wrap) div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/afe_tx.sv
module afe_tx
   import afe_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              os_tick,
   input  afe_mode_t         mode,
   input  logic              load_valid,
   input  logic [DATA_W-1:0] load_data,
   output logic              taken,
   output logic              line
);
   localparam int PH_W = $clog2(OVERSAMPLE);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

   logic [FRAME_W-1:0] shreg;
   logic [LEN_W-1:0]   left;
   logic [PH_W-1:0]    phase;
   logic               busy;
   logic               mode_unused;

   assign mode_unused = ^{mode.spare, mode.clk_sel};
   assign line        = shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '1;
         left  <= '0;
         phase <= '0;
         busy  <= 1'b0;
         taken <= 1'b0;
      end else begin
         taken <= 1'b0;
         if (!enable) begin
            shreg <= '1;
            left  <= '0;
            phase <= '0;
            busy  <= 1'b0;
         end else if (!busy) begin
            if (load_valid) begin
               shreg <= frame_bits(load_data, mode);
               left  <= frame_len(mode);
               phase <= '0;
               busy  <= 1'b1;
               taken <= 1'b1;
            end
         end else if (os_tick) begin
            if (phase == PH_LAST) begin
               phase <= '0;
               shreg <= {1'b1, shreg[FRAME_W-1:1]};
               left  <= left - 1'b1;
               if (left == LEN_W'(1)) busy <= 1'b0;
            end else begin
               phase <= phase + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/afe_rx.sv
module afe_rx
   import afe_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              os_tick,
   input  afe_mode_t         mode,
   input  logic              line,
   input  logic              read_ack,
   output logic [DATA_W-1:0] data,
   output logic              done,
   output logic              overrun,
   output logic              frame_err,
   output logic              parity_err
);
   localparam int PH_W  = $clog2(OVERSAMPLE);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVERSAMPLE / 2 - 1);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

   rx_state_e         st;
   logic [PH_W-1:0]   phase;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  idx_last;
   logic [DATA_W-1:0] shift;
   logic              par_bit;
   logic              armed;
   logic              pending;
   logic              finish;
   logic              mode_unused;

   assign mode_unused = ^{mode.spare, mode.clk_sel, mode.two_stop};
   assign idx_last    = IDX_W'(data_bits(mode) - 1);
   assign finish      = enable && os_tick && (st == RX_STOP) && (phase == PH_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending <= 1'b0;
      else if (finish) pending <= 1'b1;
      else if (read_ack) pending <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= RX_IDLE;
         phase      <= '0;
         idx        <= '0;
         shift      <= '0;
         par_bit    <= 1'b0;
         armed      <= 1'b0;
         data       <= '0;
         done       <= 1'b0;
         overrun    <= 1'b0;
         frame_err  <= 1'b0;
         parity_err <= 1'b0;
      end else begin
         done       <= 1'b0;
         overrun    <= 1'b0;
         frame_err  <= 1'b0;
         parity_err <= 1'b0;
         if (!enable) begin
            st    <= RX_IDLE;
            armed <= 1'b0;
            phase <= '0;
         end else if (os_tick) begin
            unique case (st)
               RX_IDLE: begin
                  armed <= line;
                  if (armed && !line) begin
                     st    <= RX_START;
                     phase <= '0;
                  end
               end
               RX_START: begin
                  if (phase == PH_MID) begin
                     phase <= '0;
                     if (line) begin
                        st    <= RX_IDLE;
                        armed <= 1'b1;
                     end else begin
                        st    <= RX_DATA;
                        idx   <= '0;
                        shift <= '0;
                     end
                  end else begin
                     phase <= phase + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (phase == PH_LAST) begin
                     phase      <= '0;
                     shift[idx] <= line;
                     if (idx == idx_last) st <= mode.par_on ? RX_PAR : RX_STOP;
                     else idx <= idx + 1'b1;
                  end else begin
                     phase <= phase + 1'b1;
                  end
               end
               RX_PAR: begin
                  if (phase == PH_LAST) begin
                     phase   <= '0;
                     par_bit <= line;
                     st      <= RX_STOP;
                  end else begin
                     phase <= phase + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (phase == PH_LAST) begin
                     phase      <= '0;
                     st         <= RX_IDLE;
                     armed      <= line;
                     data       <= shift;
                     done       <= 1'b1;
                     frame_err  <= !line;
                     parity_err <= mode.par_on && ((^shift ^ par_bit) != mode.par_odd);
                     overrun    <= pending && !read_ack;
                  end else begin
                     phase <= phase + 1'b1;
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/afe_top.sv
module afe_top
   import afe_pkg::*;
#(
   parameter int OVERSAMPLE    = 16,
   parameter int SYNC_STAGES   = 2,
   parameter int RATE_W        = 8,
   parameter int CKS_W         = 2,
   parameter int PRE_BASE      = 2,
   parameter int PRE_STEP_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        mode_i,
   input  logic [RATE_W-1:0] rate_i,
   input  logic              tx_en_i,
   input  logic              rx_en_i,
   input  logic              tx_valid_i,
   input  logic [DATA_W-1:0] tx_data_i,
   output logic              tx_taken_o,
   output logic              tx_line_o,
   input  logic              rx_line_i,
   input  logic              rx_read_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_done_o,
   output logic              rx_overrun_o,
   output logic              rx_frame_err_o,
   output logic              rx_parity_err_o
);
   if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
      $error("afe_top: OVERSAMPLE must be even and at least 4");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("afe_top: SYNC_STAGES must not be negative");
   end
   if (CKS_W != 2) begin : g_bad_cks
      $error("afe_top: the mode byte carries a 2-bit clock select");
   end

   afe_mode_t mode;
   logic      os_tick;
   logic      rx_line_s;

   assign mode = afe_mode_t'(mode_i);

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_line_s = rx_line_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else begin
            sync_q[0] <= rx_line_i;
            for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
         end
      end
      assign rx_line_s = sync_q[SYNC_STAGES-1];
   end

   afe_baud #(
      .CKS_W(CKS_W), .RATE_W(RATE_W), .PRE_BASE(PRE_BASE), .PRE_STEP_LOG2(PRE_STEP_LOG2)
   ) u_baud (
      .clk(clk), .rst_n(rst_n), .run(tx_en_i | rx_en_i),
      .clk_sel(mode.clk_sel), .rate(rate_i), .os_tick(os_tick)
   );

   afe_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
      .clk(clk), .rst_n(rst_n), .enable(tx_en_i), .os_tick(os_tick), .mode(mode),
      .load_valid(tx_valid_i), .load_data(tx_data_i), .taken(tx_taken_o), .line(tx_line_o)
   );

   afe_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
      .clk(clk), .rst_n(rst_n), .enable(rx_en_i), .os_tick(os_tick), .mode(mode),
      .line(rx_line_s), .read_ack(rx_read_i), .data(rx_data_o), .done(rx_done_o),
      .overrun(rx_overrun_o), .frame_err(rx_frame_err_o), .parity_err(rx_parity_err_o)
   );
endmodule

// File: rtl/afe_top_chk.sv
module afe_top_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] mode_i,
   input logic       tx_en_i,
   input logic       rx_en_i,
   input logic       tx_valid_i,
   input logic       tx_taken_o,
   input logic       tx_line_o,
   input logic [7:0] rx_data_o,
   input logic       rx_done_o,
   input logic       rx_overrun_o,
   input logic       rx_frame_err_o,
   input logic       rx_parity_err_o
);
   // R7
   tx_quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en_i |=> tx_line_o);

   // R7
   tx_disabled_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_taken_o |-> $past(tx_en_i && tx_valid_i));

   // R6
   taken_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_taken_o |=> !tx_taken_o);

   // R8
   rx_disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en_i |=> !rx_done_o);

   // R9
   flags_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_overrun_o || rx_frame_err_o || rx_parity_err_o) |-> rx_done_o);

   // R4
   parity_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_parity_err_o |-> $past(mode_i[4]));

   // R2
   short_char_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done_o && $past(mode_i[5])) |-> !rx_data_o[7]);
endmodule

bind afe_top afe_top_chk u_afe_top_chk (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .tx_en_i(tx_en_i), .rx_en_i(rx_en_i),
   .tx_valid_i(tx_valid_i), .tx_taken_o(tx_taken_o), .tx_line_o(tx_line_o),
   .rx_data_o(rx_data_o), .rx_done_o(rx_done_o), .rx_overrun_o(rx_overrun_o),
   .rx_frame_err_o(rx_frame_err_o), .rx_parity_err_o(rx_parity_err_o)
);

// File: tb/afe_top_bench.sv
module afe_top_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] mode_i = 8'h00;
   logic [7:0] rate_i = 8'h00;
   logic       tx_en_i = 1'b0;
   logic       rx_en_i = 1'b0;
   logic       tx_valid_i = 1'b0;
   logic [7:0] tx_data_i = 8'h00;
   logic       rx_read_i = 1'b1;
   logic       loop_sel = 1'b0;
   logic       drv_line = 1'b1;
   logic       rx_line_i;
   logic       tx_taken_o, tx_line_o, rx_done_o, rx_overrun_o, rx_frame_err_o, rx_parity_err_o;
   logic [7:0] rx_data_o;

   assign rx_line_i = loop_sel ? tx_line_o : drv_line;

   always #(CLK_PERIOD / 2) clk = ~clk;

   afe_top u_afe_top (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rate_i(rate_i), .tx_en_i(tx_en_i),
      .rx_en_i(rx_en_i), .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
      .tx_taken_o(tx_taken_o), .tx_line_o(tx_line_o), .rx_line_i(rx_line_i),
      .rx_read_i(rx_read_i), .rx_data_o(rx_data_o), .rx_done_o(rx_done_o),
      .rx_overrun_o(rx_overrun_o), .rx_frame_err_o(rx_frame_err_o),
      .rx_parity_err_o(rx_parity_err_o)
   );

   typedef struct {
      logic [7:0] d;
      logic       fe;
      logic       pe;
      logic       ov;
      string      req;
   } exp_t;

   exp_t  sb[$];
   exp_t  mon_e;
   int    vectors = 0;
   int    miscompares = 0;
   int    done_seen = 0;
   int    cyc = 0;
   bit    finished = 0;
   int    cur_bit = 32;
   int    nd = 8;
   logic  c_short, c_pon, c_podd, c_two;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, string what, int act, int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   // monitor: pop and compare each received character
   always @(negedge clk) begin
      if (rst_n && rx_done_o) begin
         done_seen++;
         if (sb.size() == 0) begin
            check(0, "R9", "unexpected character", rx_data_o, 0);
         end else begin
            mon_e = sb.pop_front();
            check(rx_data_o == mon_e.d, mon_e.req, "data", rx_data_o, mon_e.d);
            check(rx_frame_err_o == mon_e.fe, "R10", "frame error", rx_frame_err_o, mon_e.fe);
            check(rx_parity_err_o == mon_e.pe, "R11", "parity error", rx_parity_err_o, mon_e.pe);
            check(rx_overrun_o == mon_e.ov, "R12", "overrun", rx_overrun_o, mon_e.ov);
         end
      end
   end

   task automatic set_mode(logic sh, logic pon, logic podd, logic two, logic [1:0] cs, logic [7:0] n);
      c_short = sh; c_pon = pon; c_podd = podd; c_two = two;
      mode_i  = {2'b00, sh, pon, podd, two, cs};
      rate_i  = n;
      cur_bit = 32 * (1 << (2 * int'(cs))) * (int'(n) + 1);
      nd      = sh ? 7 : 8;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [7:0] dmask(logic [7:0] d);
      return c_short ? (d & 8'h7F) : d;
   endfunction

   task automatic hold_bit(logic v);
      drv_line = v;
      repeat (cur_bit) @(negedge clk);
   endtask

   task automatic drive_frame(logic [7:0] d, bit bad_par, bit bad_stop, bit ov, bit expect_rx, string req);
      exp_t e;
      logic p;
      if (expect_rx) begin
         e.d = dmask(d); e.fe = bad_stop; e.pe = bad_par && c_pon; e.ov = ov; e.req = req;
         sb.push_back(e);
      end
      hold_bit(1'b0);
      for (int i = 0; i < nd; i++) hold_bit(d[i]);
      if (c_pon) begin
         p = (^dmask(d)) ^ c_podd ^ bad_par;
         hold_bit(p);
      end
      hold_bit(!bad_stop);
      if (c_two) hold_bit(1'b1);
      hold_bit(1'b1);
      hold_bit(1'b1);
   endtask

   task automatic send_tx(logic [7:0] d, string req, output int t);
      exp_t e;
      e.d = dmask(d); e.fe = 0; e.pe = 0; e.ov = 0; e.req = req;
      sb.push_back(e);
      tx_data_i  = d;
      tx_valid_i = 1'b1;
      do @(negedge clk); while (!tx_taken_o);
      t = cyc;
      tx_valid_i = 1'b0;
   endtask

   task automatic drain(string req);
      int lim = cur_bit * 24;
      while (sb.size() != 0 && lim > 0) begin
         @(negedge clk);
         lim--;
      end
      check(sb.size() == 0, req, "characters still expected", sb.size(), 0);
      repeat (cur_bit * 2) @(negedge clk);
   endtask

   // three back-to-back frames over loopback; spacing of the last two is exact
   task automatic burst(logic [7:0] a, logic [7:0] b, logic [7:0] c, string req);
      int t1, t2, t3, len;
      len = 1 + nd + (c_pon ? 1 : 0) + (c_two ? 2 : 1);
      loop_sel = 1'b1;
      send_tx(a, req, t1);
      send_tx(b, req, t2);
      send_tx(c, req, t3);
      check((t3 - t2) == len * cur_bit, req, "frame spacing", t3 - t2, len * cur_bit);
      drain(req);
      loop_sel = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int base, bad, t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 idle state after reset
      check(tx_line_o == 1'b1, "R1", "idle line", tx_line_o, 1);
      check(rx_done_o == 1'b0 && tx_taken_o == 1'b0, "R6", "no events after reset",
            {rx_done_o, tx_taken_o}, 0);
      tx_en_i = 1'b1;
      rx_en_i = 1'b1;

      // R1 R5 R6: 8N1, fastest rate
      set_mode(0, 0, 0, 0, 2'd0, 8'd0);
      burst(8'hA5, 8'h3C, 8'h01, "R1");
      // R2 R3 R5: 7 data bits, even parity, two stops, prescale 4, N=2
      set_mode(1, 1, 0, 1, 2'd1, 8'd2);
      burst(8'hFF, 8'h80, 8'h55, "R2");
      // R4 R5: odd parity, prescale 16
      set_mode(0, 1, 1, 0, 2'd2, 8'd0);
      burst(8'h96, 8'h00, 8'h7E, "R5");
      // R4: odd select ignored while parity is off, frame stays 10 bits
      set_mode(0, 0, 1, 0, 2'd0, 8'd1);
      burst(8'h96, 8'hC3, 8'h18, "R4");
      drive_frame(8'h96, 0, 0, 0, 1, "R4");
      drain("R4");

      // R9 R3: bench-driven frames, receiver ignores second stop level
      set_mode(0, 0, 0, 1, 2'd0, 8'd0);
      drive_frame(8'h5A, 0, 0, 0, 1, "R9");
      drive_frame(8'hE1, 0, 0, 0, 1, "R3");
      drain("R9");
      // R11: parity error, both senses
      set_mode(0, 1, 0, 0, 2'd0, 8'd0);
      drive_frame(8'h33, 1, 0, 0, 1, "R11");
      drive_frame(8'h34, 0, 0, 0, 1, "R11");
      set_mode(0, 1, 1, 0, 2'd0, 8'd0);
      drive_frame(8'h35, 1, 0, 0, 1, "R11");
      drive_frame(8'h36, 0, 0, 0, 1, "R11");
      drain("R11");
      // R10: first stop sampled low
      set_mode(0, 0, 0, 0, 2'd0, 8'd0);
      drive_frame(8'h71, 0, 1, 0, 1, "R10");
      drive_frame(8'h72, 0, 0, 0, 1, "R10");
      drain("R10");
      // R2: 7-bit receive of a bench frame
      set_mode(1, 0, 0, 0, 2'd0, 8'd0);
      drive_frame(8'hC9, 0, 0, 0, 1, "R2");
      drain("R2");
      // R12: overrun when previous character is unread
      set_mode(0, 0, 0, 0, 2'd0, 8'd0);
      rx_read_i = 1'b0;
      drive_frame(8'h11, 0, 0, 0, 1, "R12");
      drive_frame(8'h22, 0, 0, 1, 1, "R12");
      drain("R12");
      rx_read_i = 1'b1;
      repeat (4) @(negedge clk);
      drive_frame(8'h44, 0, 0, 0, 1, "R12");
      drain("R12");

      // R13: short low pulse is rejected, next frame received
      base = done_seen;
      drv_line = 1'b0;
      repeat (cur_bit / 4) @(negedge clk);
      drv_line = 1'b1;
      repeat (cur_bit * 14) @(negedge clk);
      check(done_seen == base, "R13", "glitch reported", done_seen - base, 0);
      drive_frame(8'h69, 0, 0, 0, 1, "R13");
      drain("R13");

      // R8: receive half disabled
      rx_en_i = 1'b0;
      base = done_seen;
      drive_frame(8'h0F, 0, 0, 0, 0, "R8");
      check(done_seen == base, "R8", "character while disabled", done_seen - base, 0);
      rx_en_i = 1'b1;
      repeat (cur_bit * 2) @(negedge clk);
      drive_frame(8'hF0, 0, 0, 0, 1, "R8");
      drain("R8");

      // R7: transmit half disabled
      tx_en_i = 1'b0;
      tx_valid_i = 1'b1;
      tx_data_i = 8'h00;
      bad = 0;
      repeat (cur_bit * 12) begin
         @(negedge clk);
         if (tx_taken_o || !tx_line_o) bad++;
      end
      check(bad == 0, "R7", "activity while disabled", bad, 0);
      tx_valid_i = 1'b0;
      tx_en_i = 1'b1;
      repeat (4) @(negedge clk);
      loop_sel = 1'b1;
      send_tx(8'hB7, "R7", t);
      drain("R7");
      loop_sel = 1'b0;

      finish_run();
   end
endmodule